// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM from a three-wire serial audio link (bit clock, frame clock, data) and turns it into parallel sample pairs. The link clocks are treated as ordinary inputs. They are oversampled in the system clock domain through a synchronizer, so the system clock must run at least eight times faster than the bit clock. Four framings are supported, selected by a 2-bit format input: I2S, left-justified, right-justified in a fixed 64-bit frame, and a pulse-synchronised DSP framing. For the right-justified framing, a 2-bit word-length input places the start of each word within its channel slot.

Each completed frame produces one 24-bit signed left sample and one 24-bit signed right sample. Both are delivered together on a valid/ready output. The serial link cannot be stalled, so back-pressure works as a one-entry mailbox:
- A pair stays on the outputs with valid high until the consumer takes it with ready.
- If a newer pair completes before that happens, the newer pair replaces the waiting one.

When ready is held high, valid is a single-cycle strobe.

The format and word-length inputs are expected to change only while the block is in reset.

Top module: `pcm_serial_rx`

## Requirements
- R1: Format code 11 selects left-justified framing. Frame clock high marks the left channel, the MSB is the bit sampled at the frame-clock transition, and data is sampled on the rising bit-clock edge.
- R2: Format code 00 selects I2S framing. Frame clock low marks the left channel, the MSB is sampled one bit clock after the frame-clock transition, and data is sampled on the rising edge.
- R3: Format code 01 selects right-justified framing in a 64-bit frame, with frame clock high for left and 32 bit slots per channel. Word-length code 00 gives 24 bits starting at slot 8, code 01 gives 20 bits starting at slot 12, and codes 10 and 11 give 16 bits starting at slot 16. Bits in the slots before the word are ignored.
- R4: Format code 10 selects DSP framing. A frame-clock high pulse of one or more bit clocks precedes each channel, and the MSB is the first bit sampled after the pulse ends. Data is sampled on the falling edge. The first pulse after reset is the left channel, and the channels alternate after that.
- R5: A word shorter than 24 bits is placed MSB-aligned in the 24-bit output, with the unused LSBs zero.
- R6: In every framing except right-justified, bits of a word beyond the 24th are discarded.
- R7: A pair becomes valid once the left channel of the following frame has started, with left and right updated in the same cycle. With ready high, valid lasts exactly one cycle.
- R8: While valid is high and ready is low, valid stays high and the held pair is replaced only by a newer completed pair.
- R9: After reset, valid is low and both sample outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sai_sck | input | 1 | Serial bit clock (oversampled) |
| sai_fs | input | 1 | Serial frame clock |
| sai_sd | input | 1 | Serial data, MSB first, two's complement |
| fmt_sel | input | 2 | Framing: 00 I2S, 01 right-justified, 10 DSP, 11 left-justified |
| wlen_sel | input | 2 | Right-justified word length: 00 24, 01 20, 1x 16 bits |
| smp_ready | input | 1 | Consumer accepts the pair on a cycle with valid high |
| smp_valid | output | 1 | Sample pair available |
| smp_left | output | 24 | Left sample, signed, MSB-aligned |
| smp_right | output | 24 | Right sample, signed, MSB-aligned |

## Verification
The hardest case to reach from the ports is a waiting pair being replaced by a newer one. This needs ready held low across two whole serial frames while the link keeps running. The stimulus drops ready before sending a frame, then checks the outputs partway through the next frame's left channel, where the first pair must be waiting. It checks again after a further frame, where the second pair must have replaced the first, and only then raises ready. The right-justified case is also built to catch misplacement: the slots before each word carry random bits, so a word started too early shows up as corrupted samples.

// File: rtl/sai_pkg.sv
package sai_pkg;
  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_RJ  = 2'b01,
    FMT_DSP = 2'b10,
    FMT_LJ  = 2'b11
  } sai_fmt_e;

  // word length for the right-justified framing
  function automatic int rj_bits(input logic [1:0] wl);
    case (wl)
      2'b00:   return 24;
      2'b01:   return 20;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/sai_pin_sync.sv
// Synchronizes a group of link pins; lane 0 is the bit clock and gets edge flags.
module sai_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] level,
  output logic             rise0,
  output logic             fall0
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;
  logic                         lane0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= pins;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane0_q <= 1'b0;
    else        lane0_q <= pipe[STAGES-1][0];
  end

  assign level = pipe[STAGES-1];
  assign rise0 = level[0] & ~lane0_q;
  assign fall0 = ~level[0] & lane0_q;
endmodule

// File: rtl/sai_deframer.sv
// Finds channel boundaries for the selected framing and assembles words.
module sai_deframer
  import sai_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int FRAME_BITS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fmt,
  input  logic [1:0]          wlen,
  input  logic                smp_evt,
  input  logic                fs_lv,
  input  logic                sd_lv,
  output logic                pair_load,
  output logic [SAMPLE_W-1:0] pair_left,
  output logic [SAMPLE_W-1:0] pair_right
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam int HALF  = FRAME_BITS / 2;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS - 1);

  sai_fmt_e            fmt_e;
  logic                fs_prev, active, cur_left, got_left, dsp_left_next;
  logic [CNT_W-1:0]    cnt, cnt_n;
  logic [SAMPLE_W-1:0] acc, acc_n, lhold;
  logic                bnd, new_left;
  int                  off, limit, pos;

  assign fmt_e = sai_fmt_e'(fmt);

  always_comb begin
    bnd      = (fs_lv != fs_prev);
    new_left = fs_lv;
    off      = 0;
    limit    = SAMPLE_W;
    case (fmt_e)
      FMT_I2S: begin new_left = ~fs_lv; off = 1; end
      FMT_RJ:  begin limit = rj_bits(wlen); off = HALF - rj_bits(wlen); end
      FMT_DSP: begin bnd = fs_prev & ~fs_lv; new_left = dsp_left_next; end
      default: ;
    endcase
    if (bnd)                 cnt_n = '0;
    else if (cnt == CNT_MAX) cnt_n = cnt;
    else                     cnt_n = cnt + 1'b1;
    pos   = int'(cnt_n) - off;
    acc_n = bnd ? '0 : acc;
    if ((active || bnd) && pos >= 0 && pos < limit && pos < SAMPLE_W)
      acc_n[SAMPLE_W-1-pos] = sd_lv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev       <= 1'b0;
      cnt           <= '0;
      acc           <= '0;
      lhold         <= '0;
      active        <= 1'b0;
      cur_left      <= 1'b0;
      got_left      <= 1'b0;
      dsp_left_next <= 1'b1;
      pair_load     <= 1'b0;
      pair_left     <= '0;
      pair_right    <= '0;
    end else begin
      pair_load <= 1'b0;
      if (smp_evt) begin
        fs_prev <= fs_lv;
        cnt     <= cnt_n;
        acc     <= acc_n;
        if (bnd) begin
          active   <= 1'b1;
          cur_left <= new_left;
          if (fmt_e == FMT_DSP) dsp_left_next <= ~new_left;
          if (active && cur_left) begin
            lhold    <= acc;
            got_left <= 1'b1;
          end else if (active && got_left) begin
            pair_load  <= 1'b1;
            pair_left  <= lhold;
            pair_right <= acc;
            got_left   <= 1'b0;
          end
        end
      end
    end
  end

  // R3: 16-bit right-justified words never touch the low byte of the word
  assert_rj16_low_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_e == FMT_RJ && wlen[1]) |-> (acc[SAMPLE_W-17:0] == '0));

  // R6: the slot counter stops at the end of the frame instead of wrapping
  assert_cnt_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_evt && !bnd && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/sai_out_buf.sv
// One-entry mailbox: a completed pair waits for ready, newer pairs replace it.
module sai_out_buf #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] d_left,
  input  logic [SAMPLE_W-1:0] d_right,
  input  logic                ready,
  output logic                valid,
  output logic [SAMPLE_W-1:0] q_left,
  output logic [SAMPLE_W-1:0] q_right
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      q_left  <= '0;
      q_right <= '0;
    end else if (load) begin
      valid   <= 1'b1;
      q_left  <= d_left;
      q_right <= d_right;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

  assert_valid_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> valid);

  assert_pair_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> ($stable(q_left) && $stable(q_right)));

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !load) |=> !valid);

  assert_load_shows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (valid && q_left == $past(d_left) && q_right == $past(d_right)));
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import sai_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int FRAME_BITS  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sai_sck,
  input  logic                sai_fs,
  input  logic                sai_sd,
  input  logic [1:0]          fmt_sel,
  input  logic [1:0]          wlen_sel,
  input  logic                smp_ready,
  output logic                smp_valid,
  output logic [SAMPLE_W-1:0] smp_left,
  output logic [SAMPLE_W-1:0] smp_right
);
  logic [2:0]          lv;
  logic                sck_rise, sck_fall, smp_evt, pair_load;
  logic [SAMPLE_W-1:0] pair_left, pair_right;

  sai_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pins  ({sai_sd, sai_fs, sai_sck}),
    .level (lv),
    .rise0 (sck_rise),
    .fall0 (sck_fall)
  );

  // DSP framing samples on the falling bit-clock edge, all others on the rising one
  assign smp_evt = (sai_fmt_e'(fmt_sel) == FMT_DSP) ? sck_fall : sck_rise;

  sai_deframer #(.SAMPLE_W(SAMPLE_W), .FRAME_BITS(FRAME_BITS)) u_deframe (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt        (fmt_sel),
    .wlen       (wlen_sel),
    .smp_evt    (smp_evt),
    .fs_lv      (lv[1]),
    .sd_lv      (lv[2]),
    .pair_load  (pair_load),
    .pair_left  (pair_left),
    .pair_right (pair_right)
  );

  sai_out_buf #(.SAMPLE_W(SAMPLE_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (pair_load),
    .d_left  (pair_left),
    .d_right (pair_right),
    .ready   (smp_ready),
    .valid   (smp_valid),
    .q_left  (smp_left),
    .q_right (smp_right)
  );
endmodule

// File: tb/sim_pcm_serial_rx.sv
module sim_pcm_serial_rx;
  localparam int CLK_P = 10;
  localparam int HB    = 4;  // system clocks per bit-clock half period

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sai_sck = 1'b0, sai_fs = 1'b0, sai_sd = 1'b0;
  logic [1:0]  fmt_sel = 2'b00, wlen_sel = 2'b00;
  logic        smp_ready = 1'b1;
  logic        smp_valid;
  logic [23:0] smp_left, smp_right;

  int n_chk = 0, n_bad = 0;
  logic [47:0] expq[$];
  string       tagq[$];
  bit          took_prev = 1'b0;
  bit          idle_hi = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pcm_serial_rx u0 (
    .clk(clk), .rst_n(rst_n), .sai_sck(sai_sck), .sai_fs(sai_fs), .sai_sd(sai_sd),
    .fmt_sel(fmt_sel), .wlen_sel(wlen_sel), .smp_ready(smp_ready),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right)
  );

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor accepted pairs and the one-cycle strobe (R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (took_prev) check(!smp_valid, "R7 strobe", {47'd0, smp_valid}, 48'd0);
      if (smp_valid && smp_ready) begin
        if (expq.size() == 0) check(1'b0, "R7 unexpected pair", {smp_left, smp_right}, 48'd0);
        else begin
          logic [47:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check({smp_left, smp_right} == e, t, {smp_left, smp_right}, e);
        end
      end
      took_prev = smp_valid && smp_ready;
    end else took_prev = 1'b0;
  end

  function automatic logic [23:0] exp24(input logic [31:0] w, input int nb);
    logic [23:0] e;
    for (int i = 0; i < 24; i++) e[23-i] = (nb-1-i >= 0) ? w[nb-1-i] : 1'b0;
    return e;
  endfunction

  function automatic int rj_n(input logic [1:0] wl);
    return (wl == 2'b00) ? 24 : (wl == 2'b01) ? 20 : 16;
  endfunction

  task automatic slot(input logic fsv, input logic sdv);
    sai_sck = idle_hi;
    sai_fs  = fsv;
    sai_sd  = sdv;
    repeat (HB) @(negedge clk);
    sai_sck = ~idle_hi;
    repeat (HB) @(negedge clk);
  endtask

  task automatic send_chan(input logic [1:0] f, input logic lvl, input logic [31:0] w,
                           input int nb, input int slots, input int pw);
    for (int s = 0; s < slots; s++) begin
      logic b, fv;
      b  = 1'b0;
      fv = lvl;
      case (f)
        2'b11: if (s < nb) b = w[nb-1-s];
        2'b00: if (s >= 1 && s-1 < nb) b = w[nb-s];
        2'b01: b = (s >= 32-nb) ? w[nb-1-(s-(32-nb))] : 1'($urandom);
        default: begin
          fv = (s < pw);
          if (s >= pw && s-pw < nb) b = w[nb-1-(s-pw)];
        end
      endcase
      slot(fv, b);
    end
  endtask

  task automatic send_frame(input logic [1:0] f, input logic [31:0] l, input logic [31:0] r,
                            input int nb, input int slots, input int pw);
    logic lv;
    lv = (f == 2'b00) ? 1'b0 : 1'b1;
    send_chan(f, lv, l, nb, slots, pw);
    send_chan(f, ~lv, r, nb, slots, pw);
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] wl);
    rst_n = 1'b0;
    fmt_sel = f;
    wlen_sel = wl;
    idle_hi = (f == 2'b10);
    sai_sck = idle_hi;
    sai_fs = (f == 2'b00);
    sai_sd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!smp_valid && smp_left == 0 && smp_right == 0, "R9 reset state",
          {smp_left[22:0], smp_right, smp_valid}, 48'd0);
    // lead-in in the right-channel / idle frame-clock level
    for (int i = 0; i < 4; i++) slot(f == 2'b00, 1'b0);
  endtask

  task automatic run_group(input logic [1:0] f, input logic [1:0] wl, input int nb,
                           input int pw, input int frames, input string tag);
    int slots;
    slots = (f == 2'b01) ? 32 : ((nb + pw + 2 > 32) ? nb + pw + 2 : 32);
    do_reset(f, wl);
    for (int k = 0; k < frames; k++) begin
      logic [31:0] l, r;
      l = $urandom;
      r = $urandom;
      if (k == 0) begin l[nb-1] = 1'b1; r[nb-1] = 1'b0; end
      expq.push_back({exp24(l, nb), exp24(r, nb)});
      tagq.push_back(tag);
      send_frame(f, l, r, nb, slots, pw);
    end
    send_frame(f, 32'd0, 32'd0, nb, slots, pw);
    repeat (20) @(negedge clk);
    check(expq.size() == 0, {tag, " R7 pairs delivered"}, 48'(expq.size()), 48'd0);
    expq.delete();
    tagq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] a_l, a_r, b_l, b_r;
    void'($urandom(32'd1977));
    run_group(2'b11, 2'b00, 24, 0, 4, "R1 LJ 24");
    run_group(2'b11, 2'b00, 16, 0, 3, "R1 R5 LJ 16");
    run_group(2'b11, 2'b00, 32, 0, 3, "R6 LJ 32");
    run_group(2'b00, 2'b00, 24, 0, 4, "R2 I2S 24");
    run_group(2'b00, 2'b00, 20, 0, 3, "R2 R5 I2S 20");
    run_group(2'b01, 2'b00, rj_n(2'b00), 0, 3, "R3 RJ 24");
    run_group(2'b01, 2'b01, rj_n(2'b01), 0, 3, "R3 RJ 20");
    run_group(2'b01, 2'b10, rj_n(2'b10), 0, 3, "R3 RJ 16a");
    run_group(2'b01, 2'b11, rj_n(2'b11), 0, 3, "R3 RJ 16b");
    run_group(2'b10, 2'b00, 24, 1, 4, "R4 DSP 24");
    run_group(2'b10, 2'b00, 16, 2, 3, "R4 R5 DSP 16 wide pulse");
    run_group(2'b10, 2'b00, 28, 1, 3, "R4 R6 DSP 28");
    for (int g = 0; g < 4; g++) begin
      logic [1:0] f;
      int nb;
      f  = (g % 3 == 0) ? 2'b11 : (g % 3 == 1) ? 2'b00 : 2'b10;
      nb = 8 + int'($urandom % 25);
      run_group(f, 2'b00, nb, 1, 3, "R5 R6 random width");
    end
    // R8: pair waits while ready is low and a newer pair replaces it
    do_reset(2'b11, 2'b00);
    smp_ready = 1'b0;
    a_l = $urandom; a_r = $urandom; b_l = $urandom; b_r = $urandom;
    send_frame(2'b11, a_l, a_r, 24, 32, 0);
    send_chan(2'b11, 1'b1, b_l, 24, 32, 0);
    check(smp_valid && {smp_left, smp_right} == {a_l[23:0], a_r[23:0]}, "R8 held pair",
          {smp_left, smp_right}, {a_l[23:0], a_r[23:0]});
    send_chan(2'b11, 1'b0, b_r, 24, 32, 0);
    send_chan(2'b11, 1'b1, 32'd0, 24, 32, 0);
    check(smp_valid && {smp_left, smp_right} == {b_l[23:0], b_r[23:0]}, "R8 replaced pair",
          {smp_left, smp_right}, {b_l[23:0], b_r[23:0]});
    expq.push_back({b_l[23:0], b_r[23:0]});
    tagq.push_back("R8 accepted pair");
    smp_ready = 1'b1;
    repeat (5) @(negedge clk);
    check(expq.size() == 0 && !smp_valid, "R8 drained", {47'd0, smp_valid}, 48'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule